// File: doc/BRIEF.md
# Glitch-Free Programmable Output Clock Divider

This block takes a fast clock and produces a slower clock that is the input divided by 2, 4, 8 or 16. A 2-bit ratio code selects the division. The result is a true/complement pair, so it can feed a differential output stage. Every selectable ratio gives a 50% duty cycle, because the output is one bit of a free-running binary counter.

Both the enable and the ratio code are sampled only at the moment the counter wraps from all ones to zero. At that point every counter bit falls together. As a result, switching the output on or off, or changing the ratio, can never cut a high phase short or add a runt pulse. A change therefore waits until the next wrap, which takes at most 16 fast-clock cycles.

The asynchronous active-low reset clears the output at once. Its release is synchronised internally over two rising edges.

Top module: `outdiv_top`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is 0 and `clk_no` is 1, with no clock edge needed to reach that state. Internal reset ends on the second rising edge after `rst_ni` rises, and the counter advances from the edge after that.
- R2: Ratio code 00 divides the clock by 2, 01 by 4, 10 by 8 and 11 by 16. With code k in effect, the output is high when the counter value modulo 2^(k+1) is at least 2^k.
- R3: Each high phase and each low phase of the running output lasts exactly 2^k fast-clock cycles, where k is the ratio code in effect.
- R4: `clk_no` is always the inverse of `clk_o`.
- R5: `oe_i` and `ratio_i` are sampled only on the rising edge at which the internal 4-bit counter goes from 15 to 0. Values present on any other edge are ignored.
- R6: While the sampled enable is 0, `clk_o` stays 0.
- R7: Changing the ratio or the enable never produces a high phase shorter than the 2^k cycles of the ratio that began it.
- R8: After reset the sampled enable is 0 and the sampled ratio code is 00 until the first counter wrap.
- R9: The output is registered, so `clk_o` reflects the counter and settings from one rising edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 2 | Division ratio code (00:/2, 01:/4, 10:/8, 11:/16) |
| oe_i | input | 1 | Active-high output enable |
| clk_o | output | 1 | Divided clock |
| clk_no | output | 1 | Complement of the divided clock |

## Verification
A new enable or ratio value affects `clk_o` only after the wrap edge that samples it and one more edge for the output register. After a wrap, the first output value under the new settings is 0. The bench model applies these steps in order at each rising edge, then compares both outputs against the model 2 ns after every rising edge, so it always reads settled values. The release of reset is modelled as a two-edge delay. Reset assertion is checked 1 ns after `rst_ni` falls, with no clock edge in between. High-phase widths are measured from the sampled output and compared with the ratio that produced each phase.

// File: rtl/outdiv_pkg.sv
package outdiv_pkg;
  localparam int unsigned DEF_CNT_W       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned sel_width(input int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/outdiv_rst_sync.sv
module outdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/outdiv_counter.sv
module outdiv_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/outdiv_cfg.sv
module outdiv_cfg #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic             oe_i,
  output logic [SEL_W-1:0] ratio_o,
  output logic             en_o
);
  logic [SEL_W-1:0] ratio_q, ratio_d;
  logic             en_q, en_d;

  always_comb begin
    ratio_d = ratio_q;
    en_d    = en_q;
    if (wrap_i) begin
      ratio_d = ratio_i;
      en_d    = oe_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      en_q    <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      en_q    <= en_d;
    end
  end

  assign ratio_o = ratio_q;
  assign en_o    = en_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(ratio_q) && $stable(en_q))); // R5
endmodule

// File: rtl/outdiv_select.sv
module outdiv_select #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic             en_i,
  output logic             out_o,
  output logic             out_no
);
  logic             out_q, out_d;
  logic [SEL_W-1:0] used_q, used_d;
  logic [CNT_W-1:0] hi_run_q, hi_run_d;

  always_comb begin
    out_d    = en_i & cnt_i[ratio_i];
    used_d   = ratio_i;
    hi_run_d = out_q ? hi_run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= 1'b0;
      used_q   <= '0;
      hi_run_q <= '0;
    end else begin
      out_q    <= out_d;
      used_q   <= used_d;
      hi_run_q <= hi_run_d;
    end
  end

  assign out_o  = out_q;
  assign out_no = ~out_q;

  AST_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !out_q); // R6

  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> hi_run_q == (CNT_W'(1) << $past(used_q))); // R7
endmodule

// File: rtl/outdiv_top.sv
module outdiv_top
  import outdiv_pkg::*;
#(
  parameter  int unsigned CNT_W       = DEF_CNT_W,
  parameter  int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned SEL_W       = sel_width(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic             oe_i,
  output logic             clk_o,
  output logic             clk_no
);
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [SEL_W-1:0] ratio_cur;
  logic             en_cur;

  outdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_int_n)
  );

  outdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  outdiv_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .wrap_i (wrap),
    .ratio_i(ratio_i),
    .oe_i   (oe_i),
    .ratio_o(ratio_cur),
    .en_o   (en_cur)
  );

  outdiv_select #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .cnt_i  (cnt),
    .ratio_i(ratio_cur),
    .en_i   (en_cur),
    .out_o  (clk_o),
    .out_no (clk_no)
  );
endmodule

// File: tb/outdiv_top_tb_top.sv
`timescale 1ns/1ps
module outdiv_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] ratio_i = 2'b00;
  logic       oe_i = 1'b0;
  logic       clk_o, clk_no;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  outdiv_top dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ratio_i(ratio_i),
    .oe_i  (oe_i),
    .clk_o (clk_o),
    .clk_no(clk_no)
  );

  // Behavioural reference: integers and arithmetic, one update per rising edge
  int m_rs0 = 0, m_rs1 = 0, m_cnt = 0, m_ratio = 0, m_en = 0, m_out = 0, m_used = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rs0 <= 0; m_rs1 <= 0; m_cnt <= 0; m_ratio <= 0;
      m_en <= 0; m_out <= 0; m_used <= 0;
    end else begin
      if (m_rs1 == 0) begin
        m_cnt <= 0; m_ratio <= 0; m_en <= 0; m_out <= 0; m_used <= 0;
      end else begin
        m_out  <= (m_en != 0 && (m_cnt % (2 << m_ratio)) >= (1 << m_ratio)) ? 1 : 0;
        m_used <= m_ratio;
        m_cnt  <= (m_cnt + 1) % 16;
        if (m_cnt == 15) begin
          m_ratio <= int'(ratio_i);
          m_en    <= int'(oe_i);
        end
      end
      m_rs1 <= m_rs0;
      m_rs0 <= 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 2 ns after each rising edge
  int run = 0;
  int prev_o = 0;
  int prev_used = 0;
  always @(posedge clk_i) begin
    #2;
    if (!done) begin
      check(cur_req, "clk_o", int'(clk_o), m_out);
      check("R4", "clk_no", int'(clk_no), 1 - m_out);
      if (!rst_ni) begin
        run = 0;
      end else if (clk_o) begin
        run++;
      end else begin
        if (prev_o != 0) check("R3", "high width", run, 1 << prev_used);
        run = 0;
      end
      prev_o = int'(clk_o);
      prev_used = m_used;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, reached without a clock edge
    cur_req = "R1";
    #1;
    check("R1", "clk_o in reset", int'(clk_o), 0);
    check("R1", "clk_no in reset", int'(clk_no), 1);
    step(4);
    // R8: enable and ratio ignored until the first wrap after reset
    cur_req = "R8";
    rst_ni = 1'b1;
    ratio_i = 2'b11;
    oe_i = 1'b1;
    step(20);
    // R2 and R9: each ratio code in turn
    cur_req = "R2";
    step(64);
    ratio_i = 2'b00; step(48);
    ratio_i = 2'b01; step(48);
    ratio_i = 2'b10; step(64);
    // R5: short pulses on inputs between wraps
    cur_req = "R5";
    step(3); ratio_i = 2'b11; step(2); ratio_i = 2'b10;
    step(5); oe_i = 1'b0; step(3); oe_i = 1'b1;
    step(40);
    // R6: output held low while disabled
    cur_req = "R6";
    oe_i = 1'b0; step(50);
    oe_i = 1'b1; step(40);
    // R7: ratio changes at odd moments
    cur_req = "R7";
    ratio_i = 2'b11; step(37);
    ratio_i = 2'b00; step(37);
    ratio_i = 2'b10; step(37);
    ratio_i = 2'b01; step(37);
    oe_i = 1'b0; step(19); oe_i = 1'b1; step(45);
    // R9: output lags the settings by one registered edge
    cur_req = "R9";
    ratio_i = 2'b00; step(40);
    // R1: reset in the middle of a run
    cur_req = "R1";
    rst_ni = 1'b0;
    #1;
    check("R1", "clk_o after async reset", int'(clk_o), 0);
    check("R1", "clk_no after async reset", int'(clk_no), 1);
    step(3);
    rst_ni = 1'b1;
    step(40);
    finish_run();
  end
endmodule